// File: doc/BRIEF.md
# Paired Word Load/Store Sequencer

This block carries out 64-bit register-pair loads and stores on a 32-bit core. Each such instruction becomes two word accesses to memory. The first access goes to the base register plus a sign-extended 12-bit offset, and the second goes four bytes higher. The two words move between memory and an even/odd register pair.

The block decodes the instruction word and decides whether it is legal. It reads the base register and the store data through one register-file read port, issues one word request at a time, and writes loaded words through a register-file write port. Each beat is checked for alignment. A misaligned beat or a memory access error is reported as an exception that carries a cause code and the faulting address.

The memory port is treated as physical. Address translation and trap entry belong to the surrounding core.

Top module: `pairls_seq`

## Requirements
- R1: An instruction is claimed (`claim` high in the same cycle as `instr_valid`) only when the XLEN parameter is 32 and `ext_en` is high. Otherwise it is not claimed and causes no activity.
- R2: A pair load has opcode bits [6:0]=0000011 and funct3 bits [14:12]=011, with its immediate in [31:20], base register in [19:15] and destination in [11:7]. A pair store has opcode 0100011 and funct3 011, with rs2 in [24:20], base in [19:15] and immediate {[31:25],[11:7]}. An odd destination or odd rs2 makes the word unclaimed, and so does any other opcode or funct3.
- R3: The first beat accesses base + sign-extended immediate. The second beat accesses that address + 4.
- R4: A load writes the first beat's data to rd in the cycle of its response, and the second beat's data to rd+1 in the cycle of its response.
- R5: A load with rd = x0 issues no memory request, raises no exception and pulses `done` in the next cycle.
- R6: A store sends register rs2 on the first beat and rs2+1 on the second. When rs2 is x0, both beats send zero.
- R7: A misaligned beat (address bits [1:0] not zero) issues no request. It raises `exc_valid` with cause 4 for a load or 6 for a store, and `exc_addr` set to that beat's address.
- R8: An error response raises `exc_valid` with cause 5 for a load or 7 for a store, and the address of the failing beat. A first-beat error prevents the second beat. When the second beat fails, the first beat's register write still stands.
- R9: `busy` is high from the cycle after acceptance until the final response, and no instruction is claimed while busy. `done` and `exc_valid` are one-cycle pulses that are never high together.
- R10: A memory request stays asserted, with stable address and data, until `mem_gnt`. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Enables pair instructions |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 32 | Instruction word |
| claim | output | 1 | Instruction recognised and accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Successful completion pulse |
| rf_raddr | output | 5 | Register read index |
| rf_rdata | input | XLEN | Register read data, same cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | XLEN | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | XLEN | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Response present |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Response is an access error |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 4 | Exception cause code |
| exc_addr | output | XLEN | Faulting address |

## Verification
The bench drives its main instance with XLEN = 32. This exercises every decode, alignment, fault and stall path against a register and memory model. A second instance with XLEN = 64 shares the instruction inputs. It shows that even a perfectly legal pair encoding is never claimed on a wider core, a case that the default build cannot reach.

// File: rtl/pairls_pkg.sv
package pairls_pkg;
    localparam int INSTR_W   = 32;
    localparam int WORD_W    = 32;
    localparam int IMM_W     = 12;
    localparam int REG_IDX_W = 5;
    localparam int CAUSE_W   = 4;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_PAIR   = 3'b011;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_LD_MISALIGN = 4'd4,
        CAUSE_LD_FAULT    = 4'd5,
        CAUSE_ST_MISALIGN = 4'd6,
        CAUSE_ST_FAULT    = 4'd7
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic                 legal;
        logic                 is_store;
        logic [REG_IDX_W-1:0] base_reg;
        logic [REG_IDX_W-1:0] pair_reg;
        logic [IMM_W-1:0]     imm;
    } pair_op_t;

    // Even register of a pair plus the beat number selects the register.
    function automatic logic [REG_IDX_W-1:0] pair_member(
        input logic [REG_IDX_W-1:0] even_reg,
        input logic                 second
    );
        return {even_reg[REG_IDX_W-1:1], second};
    endfunction
endpackage

// File: rtl/pairls_decode.sv
module pairls_decode
    import pairls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               ext_en,
    input  logic [INSTR_W-1:0] instr,
    output pair_op_t           op
);
    generate
        if (XLEN == 32) begin : g_narrow_core
            logic f3_ok;
            logic is_ld;
            logic is_st;
            always_comb begin
                f3_ok       = (instr[14:12] == F3_PAIR);
                is_ld       = (instr[6:0] == OPC_LOAD)  && f3_ok;
                is_st       = (instr[6:0] == OPC_STORE) && f3_ok;
                op.is_store = is_st;
                op.base_reg = instr[19:15];
                op.pair_reg = is_st ? instr[24:20] : instr[11:7];
                op.imm      = is_st ? {instr[31:25], instr[11:7]} : instr[31:20];
                op.legal    = ext_en && (is_ld || is_st) && !op.pair_reg[0];
            end
        end else begin : g_wide_core
            assign op = '0;
        end
    endgenerate
endmodule

// File: rtl/pairls_agu.sv
module pairls_agu
    import pairls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    input  logic             second,
    output logic [XLEN-1:0]  addr,
    output logic             misaligned
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int ALIGN_W    = $clog2(WORD_BYTES);

    logic [XLEN-1:0] offs;

    always_comb begin
        offs       = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        addr       = base + offs + (second ? XLEN'(WORD_BYTES) : '0);
        misaligned = |addr[ALIGN_W-1:0];
    end
endmodule

// File: rtl/pairls_seq.sv
module pairls_seq
    import pairls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_en,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    output logic                 claim,
    output logic                 busy,
    output logic                 done,
    output logic [REG_IDX_W-1:0] rf_raddr,
    input  logic [XLEN-1:0]      rf_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]      rf_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [XLEN-1:0]      mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_err,
    output logic                 exc_valid,
    output logic [CAUSE_W-1:0]   exc_cause,
    output logic [XLEN-1:0]      exc_addr
);
    pair_op_t        dec_op;
    pair_op_t        op_q;
    state_e          state_q;
    logic            beat_q;
    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] beat_addr;
    logic            beat_mis;
    logic            idle;
    logic            load_to_x0;

    pairls_decode #(.XLEN(XLEN)) u_decode (
        .ext_en (ext_en),
        .instr  (instr),
        .op     (dec_op)
    );

    pairls_agu #(.XLEN(XLEN)) u_agu (
        .base       (base_q),
        .imm        (op_q.imm),
        .second     (beat_q),
        .addr       (beat_addr),
        .misaligned (beat_mis)
    );

    always_comb begin
        idle       = (state_q == ST_IDLE);
        busy       = !idle;
        claim      = instr_valid && dec_op.legal && idle;
        load_to_x0 = !dec_op.is_store && (dec_op.pair_reg == '0);
        rf_raddr   = idle ? dec_op.base_reg : pair_member(op_q.pair_reg, beat_q);
        mem_req    = (state_q == ST_ISSUE) && !beat_mis;
        mem_we     = op_q.is_store;
        mem_addr   = beat_addr;
        mem_wdata  = (op_q.is_store && (op_q.pair_reg != '0)) ? rf_rdata[WORD_W-1:0] : '0;
        rf_we      = (state_q == ST_WAIT) && mem_rvalid && !mem_err && !op_q.is_store;
        rf_waddr   = pair_member(op_q.pair_reg, beat_q);
        rf_wdata   = XLEN'(mem_rdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            op_q      <= '0;
            beat_q    <= 1'b0;
            base_q    <= '0;
            done      <= 1'b0;
            exc_valid <= 1'b0;
            exc_cause <= '0;
            exc_addr  <= '0;
        end else begin
            done      <= 1'b0;
            exc_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (claim) begin
                        op_q   <= dec_op;
                        base_q <= rf_rdata;
                        beat_q <= 1'b0;
                        if (load_to_x0) done    <= 1'b1;
                        else            state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (beat_mis) begin
                        exc_valid <= 1'b1;
                        exc_cause <= op_q.is_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
                        exc_addr  <= beat_addr;
                        state_q   <= ST_IDLE;
                    end else if (mem_gnt) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            exc_valid <= 1'b1;
                            exc_cause <= op_q.is_store ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
                            exc_addr  <= beat_addr;
                            state_q   <= ST_IDLE;
                        end else if (beat_q) begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            beat_q  <= 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: completion and exception are single-cycle and exclusive
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_end_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && exc_valid));
    a_r9_no_claim_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !claim);
    // R10: request held stable until granted
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    // R7: only aligned addresses reach memory
    a_r7_req_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R4: register writes only on good responses
    a_r4_write_on_resp: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_rvalid && !mem_err));
endmodule

// File: tb/pairls_seq_bench.sv
module pairls_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_en = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        claim, busy, done, rf_we, mem_req, mem_we, exc_valid;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, exc_addr;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  exc_cause;

    logic        w_claim, w_busy, w_done, w_rf_we, w_mem_req, w_mem_we, w_exc;
    logic [4:0]  w_raddr, w_waddr;
    logic [63:0] w_wdata, w_addr, w_exc_addr;
    logic [31:0] w_mem_wdata;
    logic [3:0]  w_cause;

    logic [31:0] regs [32];
    assign rf_rdata = regs[rf_raddr];

    int checks = 0;
    int errors = 0;
    int stall_n = 0;
    bit err_on = 0;
    logic [31:0] err_addr = '0;
    bit granted = 0;
    logic [31:0] gaddr = '0;
    int wait_cnt = 0;

    logic [64:0] q_mem [$];
    logic [36:0] q_wr  [$];
    logic [36:0] q_end [$];

    always #5 clk = ~clk;

    pairls_seq u_pairls_seq (
        .clk(clk), .rst(rst), .ext_en(ext_en), .instr_valid(instr_valid), .instr(instr),
        .claim(claim), .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_addr(exc_addr)
    );

    pairls_seq #(.XLEN(64)) u_pairls_seq_w64 (
        .clk(clk), .rst(rst), .ext_en(ext_en), .instr_valid(instr_valid), .instr(instr),
        .claim(w_claim), .busy(w_busy), .done(w_done), .rf_raddr(w_raddr), .rf_rdata(64'd0),
        .rf_we(w_rf_we), .rf_waddr(w_waddr), .rf_wdata(w_wdata), .mem_req(w_mem_req),
        .mem_we(w_mem_we), .mem_addr(w_addr), .mem_wdata(w_mem_wdata), .mem_gnt(1'b0),
        .mem_rvalid(1'b0), .mem_rdata(32'd0), .mem_err(1'b0),
        .exc_valid(w_exc), .exc_cause(w_cause), .exc_addr(w_exc_addr)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction

    function automatic logic [31:0] enc_ld(input logic [11:0] imm, input logic [4:0] rs1, input logic [4:0] rd);
        return {imm, rs1, 3'b011, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_sd(input logic [11:0] imm, input logic [4:0] rs2, input logic [4:0] rs1);
        return {imm[11:5], rs2, rs1, 3'b011, imm[4:0], 7'b0100011};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = granted;
            mem_err    = granted && err_on && (gaddr == err_addr);
            mem_rdata  = granted ? memval(gaddr) : '0;
            granted    = 0;
            mem_gnt    = 0;
            #1;
            if (!rst) begin
                if (rf_we) begin
                    if (q_wr.size() == 0) chk(0, "R4", "unexpected register write", {27'd0, rf_waddr, rf_wdata}, 64'd0);
                    else begin
                        logic [36:0] e;
                        e = q_wr.pop_front();
                        chk({rf_waddr, rf_wdata} == e, "R4", "register write", {27'd0, rf_waddr, rf_wdata}, {27'd0, e});
                    end
                    if (rf_waddr != 0) regs[rf_waddr] = rf_wdata;
                end
                if (done || exc_valid) begin
                    if (q_end.size() == 0) chk(0, "R9", "unexpected completion", {31'd0, exc_valid, exc_addr}, 64'd0);
                    else begin
                        logic [36:0] e;
                        e = q_end.pop_front();
                        if (!e[36]) chk(done && !exc_valid, "R5 R9", "done expected", {62'd0, done, exc_valid}, 64'd2);
                        else chk(exc_valid && !done && {exc_cause, exc_addr} == e[35:0], "R7 R8", "exception",
                                 {27'd0, exc_valid, exc_cause, exc_addr}, {27'd0, e});
                    end
                end
                if (mem_req) begin
                    if (wait_cnt >= stall_n) begin
                        mem_gnt  = 1;
                        granted  = 1;
                        gaddr    = mem_addr;
                        wait_cnt = 0;
                        if (q_mem.size() == 0) chk(0, "R10", "unexpected request", {31'd0, mem_addr, mem_we}, 64'd0);
                        else begin
                            logic [64:0] e;
                            e = q_mem.pop_front();
                            chk({mem_we, mem_addr, mem_wdata} == e, "R3 R6 R10", "memory request",
                                {mem_addr, mem_wdata}, e[63:0]);
                        end
                    end else wait_cnt++;
                end
            end
        end
    end

    task automatic run_op(input logic [31:0] ins, input bit exp_claim, input int err_beat,
                          input bit poke, input string tag);
        logic [4:0]  rs1, rd, rs2, pr;
        logic [11:0] im;
        logic [31:0] a0, a1;
        bit          st;
        rs1 = ins[19:15];
        rd  = ins[11:7];
        rs2 = ins[24:20];
        st  = (ins[6:0] == 7'b0100011);
        im  = st ? {ins[31:25], ins[11:7]} : ins[31:20];
        pr  = st ? rs2 : rd;
        a0  = regs[rs1] + {{20{im[11]}}, im};
        a1  = a0 + 32'd4;
        err_on   = (err_beat >= 0);
        err_addr = (err_beat == 1) ? a1 : a0;
        if (exp_claim) begin
            if (!st && rd == 0) q_end.push_back({1'b0, 36'd0});
            else if (a0[1:0] != 0) q_end.push_back({1'b1, st ? 4'd6 : 4'd4, a0});
            else begin
                q_mem.push_back({st, a0, (st && pr != 0) ? regs[pr] : 32'd0});
                if (err_beat == 0) q_end.push_back({1'b1, st ? 4'd7 : 4'd5, a0});
                else begin
                    if (!st) q_wr.push_back({pr, memval(a0)});
                    q_mem.push_back({st, a1, (st && pr != 0) ? regs[pr | 5'd1] : 32'd0});
                    if (err_beat == 1) q_end.push_back({1'b1, st ? 4'd7 : 4'd5, a1});
                    else begin
                        if (!st) q_wr.push_back({pr | 5'd1, memval(a1)});
                        q_end.push_back({1'b0, 36'd0});
                    end
                end
            end
        end
        @(negedge clk);
        instr       = ins;
        instr_valid = 1;
        #2;
        chk(claim == exp_claim, tag, "claim", {63'd0, claim}, {63'd0, exp_claim});
        chk(w_claim == 0, "R1", "wide core claims nothing", {63'd0, w_claim}, 64'd0);
        @(negedge clk);
        instr_valid = 0;
        #2;
        if (exp_claim && !(!st && rd == 0))
            chk(busy == 1, "R9", "busy after accept", {63'd0, busy}, 64'd1);
        else
            chk(busy == 0, tag, "idle when nothing started", {63'd0, busy}, 64'd0);
        if (poke) begin
            instr       = enc_ld(12'd0, 5'd3, 5'd8);
            instr_valid = 1;
            #1;
            chk(claim == 0, "R9", "no claim while busy", {63'd0, claim}, 64'd0);
            @(negedge clk);
            instr_valid = 0;
        end
        while (q_end.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #2;
        chk(q_mem.size() == 0 && q_wr.size() == 0, tag, "pending expectations",
            {32'(q_mem.size()), 32'(q_wr.size())}, 64'd0);
        chk(busy == 0, "R9", "idle at end", {63'd0, busy}, 64'd0);
        err_on = 0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'd0 : {i[7:0], 24'h00_1000};
        regs[9] = 32'h0000_2002;
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        chk(!busy && !done && !exc_valid && !mem_req && !rf_we, "R9", "reset state",
            {59'd0, busy, done, exc_valid, mem_req, rf_we}, 64'd0);

        ext_en = 0;
        run_op(enc_ld(12'h010, 5'd3, 5'd4), 0, -1, 0, "R1");
        ext_en = 1;
        run_op(enc_ld(12'h010, 5'd3, 5'd5), 0, -1, 0, "R2");
        run_op(enc_sd(12'h010, 5'd7, 5'd3), 0, -1, 0, "R2");
        run_op({12'h010, 5'd3, 3'b010, 5'd4, 7'b0000011}, 0, -1, 0, "R2");
        run_op(enc_ld(12'h010, 5'd3, 5'd4), 1, -1, 0, "R3 R4");
        stall_n = 2;
        run_op(enc_ld(12'hFF8, 5'd11, 5'd12), 1, -1, 1, "R3 R10");
        stall_n = 0;
        run_op(enc_ld(12'h020, 5'd3, 5'd0), 1, -1, 0, "R5");
        run_op(enc_sd(12'h7FC, 5'd6, 5'd3), 1, -1, 0, "R6");
        stall_n = 1;
        run_op(enc_sd(12'h804, 5'd0, 5'd13), 1, -1, 0, "R6");
        stall_n = 0;
        run_op(enc_ld(12'h000, 5'd9, 5'd14), 1, -1, 0, "R7");
        run_op(enc_sd(12'h001, 5'd10, 5'd3), 1, -1, 0, "R7");
        run_op(enc_ld(12'h040, 5'd3, 5'd16), 1, 0, 0, "R8");
        run_op(enc_ld(12'h048, 5'd3, 5'd18), 1, 1, 0, "R8");
        run_op(enc_sd(12'h100, 5'd20, 5'd3), 1, 1, 0, "R8");
        run_op(enc_ld(12'h000, 5'd3, 5'd2), 1, -1, 0, "R4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule